// File: doc/BRIEF.md
# Sampled Phase-Frequency Detector with Lock Monitor

This block sits between the two divided pulse streams of a frequency synthesizer and the charge pump that steers the oscillator's control voltage. Both streams are brought into the system clock domain. A three-state phase-frequency detector then works out which stream's rising edge came first. While the reference edge leads, it asserts an active-low pump-up control. While the oscillator edge leads, it asserts an active-high pump-down control. When the edges coincide, both controls stay in their rest levels: pump-up high and pump-down low, so neither pump switch conducts.

The same comparison drives a lock monitor. For each comparison, the detector counts how many system clocks the leading flag has been held. When that count passes a programmable window, the lock-detect line goes low for the rest of the comparison. The line therefore rests high while the loop is locked and carries low-going pulses while it is not. A separate unlock flag goes high for the controller on any such pulse, and the controller may disable the radio on it. The flag only falls again after a programmable run of consecutive clean comparisons.

Top module: `pfd_lock_top`

## Requirements
- R1: While `rst` is held and on the first cycle after it, `pump_up_n` is 1, `pump_dn` is 0, `lock_det` is 1 and `unlock` is 1.
- R2: Each input pulse must be high for at least one clock and low for at least one clock between pulses. When a `ref_pulse` rising edge precedes a `vco_pulse` rising edge by d clocks, `pump_up_n` is low for exactly d clock cycles and `pump_dn` stays 0.
- R3: When a `vco_pulse` rising edge precedes a `ref_pulse` rising edge by d clocks, `pump_dn` is high for exactly d clock cycles and `pump_up_n` stays 1.
- R4: Rising edges of both inputs sampled in the same clock leave `pump_up_n` at 1, `pump_dn` at 0 and `lock_det` at 1.
- R5: A second rising edge on the leading input before the lagging edge arrives does not restart the comparison. The active pump stays asserted from the first leading edge until the lagging edge.
- R6: `pump_up_n` low and `pump_dn` high never occur in the same cycle.
- R7: In a comparison with lead d, `lock_det` is low for d − LOCK_WIN cycles when d > LOCK_WIN. Otherwise it stays 1.
- R8: `unlock` is 1 in the cycle after any cycle in which `lock_det` is 0.
- R9: `unlock` falls only after RELOCK_CNT consecutive comparisons without a `lock_det` low cycle. A comparison with a low cycle restarts that count.
- R10: `lock_det` is low only in cycles where one of the pump controls is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_pulse | input | 1 | Divided reference pulse stream |
| vco_pulse | input | 1 | Divided oscillator pulse stream |
| pump_up_n | output | 1 | Pump-up control, active low, rests high |
| pump_dn | output | 1 | Pump-down control, active high, rests low |
| lock_det | output | 1 | High when locked, low-going pulses on phase error beyond the window |
| unlock | output | 1 | Controller unlock flag, high while lock is not established |

## Verification
The bench pushes leads on both sides of the window. It uses a lead of exactly LOCK_WIN, which must give no low pulse, and a lead of LOCK_WIN + 1, which must give a single low cycle. An off-by-one comparator would show up as a missing or extra lock-detect pulse. It repeats a leading edge before the lagging one: a detector that restarted or cleared on the repeat would shorten the pump pulse. The relock run places a bad comparison in the middle of a clean streak. A counter that failed to restart would drop `unlock` too early, and one that reset on every comparison would never drop it.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_REF_LEAD = 2'd1,
        PH_VCO_LEAD = 2'd2
    } phase_state_e;

    typedef struct packed {
        logic vco_rise;
        logic ref_rise;
    } edge_pair_t;

    typedef struct packed {
        logic done;
        logic active;
    } cmp_status_t;

    function automatic int unsigned bits_for(int unsigned maxv);
        return (maxv < 2) ? 1 : $clog2(maxv + 1);
    endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] sh;
    logic              prev_q;
    logic              last;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= {sh[STAGES-2:0], din};
            end
        end
    endgenerate

    assign last = sh[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= last;
    end

    assign rise = last & ~prev_q;
endmodule

// File: rtl/pfd_tristate_core.sv
module pfd_tristate_core
    import pfd_pkg::*;
#(
    parameter int LOCK_WIN = 8,
    parameter int ERR_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  edge_pair_t       edges,
    output phase_state_e     state,
    output cmp_status_t      status,
    output logic [ERR_W-1:0] err_cnt
);
    localparam logic [ERR_W-1:0] SAT = ERR_W'(LOCK_WIN);

    phase_state_e     st_q, st_d;
    logic [ERR_W-1:0] cnt_q;
    logic             done;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        unique case (st_q)
            PH_IDLE: begin
                if (edges.ref_rise && edges.vco_rise) done = 1'b1;
                else if (edges.ref_rise)              st_d = PH_REF_LEAD;
                else if (edges.vco_rise)              st_d = PH_VCO_LEAD;
            end
            PH_REF_LEAD: begin
                if (edges.vco_rise) begin
                    st_d = PH_IDLE;
                    done = 1'b1;
                end
            end
            PH_VCO_LEAD: begin
                if (edges.ref_rise) begin
                    st_d = PH_IDLE;
                    done = 1'b1;
                end
            end
            default: st_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == PH_IDLE)  cnt_q <= '0;
            else if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign state         = st_q;
    assign status.done   = done;
    assign status.active = (st_q != PH_IDLE);
    assign err_cnt       = cnt_q;
endmodule

// File: rtl/pfd_lock_monitor.sv
module pfd_lock_monitor
    import pfd_pkg::*;
#(
    parameter int LOCK_WIN   = 8,
    parameter int RELOCK_CNT = 4,
    parameter int ERR_W      = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  cmp_status_t      status,
    input  logic [ERR_W-1:0] err_cnt,
    output logic             lock_low,
    output logic             unlock
);
    localparam int CLEAN_W = bits_for(RELOCK_CNT - 1);
    localparam logic [ERR_W-1:0]   WIN_V  = ERR_W'(LOCK_WIN);
    localparam logic [CLEAN_W-1:0] LAST_C = CLEAN_W'(RELOCK_CNT - 1);

    logic [CLEAN_W-1:0] clean_q;
    logic               unlock_q;

    assign lock_low = status.active && (err_cnt == WIN_V);

    always_ff @(posedge clk) begin
        if (rst) begin
            unlock_q <= 1'b1;
            clean_q  <= '0;
        end else if (lock_low) begin
            unlock_q <= 1'b1;
            clean_q  <= '0;
        end else if (status.done && unlock_q) begin
            if (clean_q == LAST_C) begin
                unlock_q <= 1'b0;
                clean_q  <= '0;
            end else begin
                clean_q <= clean_q + 1'b1;
            end
        end
    end

    assign unlock = unlock_q;
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
    import pfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LOCK_WIN    = 8,
    parameter int RELOCK_CNT  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_pulse,
    input  logic vco_pulse,
    output logic pump_up_n,
    output logic pump_dn,
    output logic lock_det,
    output logic unlock
);
    localparam int ERR_W = bits_for(LOCK_WIN);

    logic [1:0]       raw;
    logic [1:0]       rise;
    edge_pair_t       edges;
    phase_state_e     state;
    cmp_status_t      status;
    logic [ERR_W-1:0] err_cnt;
    logic             lock_low;

    assign raw = {vco_pulse, ref_pulse};

    generate
        for (genvar i = 0; i < 2; i++) begin : g_in
            pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk  (clk),
                .rst  (rst),
                .din  (raw[i]),
                .rise (rise[i])
            );
        end
    endgenerate

    assign edges.ref_rise = rise[0];
    assign edges.vco_rise = rise[1];

    pfd_tristate_core #(.LOCK_WIN(LOCK_WIN), .ERR_W(ERR_W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .edges   (edges),
        .state   (state),
        .status  (status),
        .err_cnt (err_cnt)
    );

    pfd_lock_monitor #(
        .LOCK_WIN(LOCK_WIN), .RELOCK_CNT(RELOCK_CNT), .ERR_W(ERR_W)
    ) u_mon (
        .clk      (clk),
        .rst      (rst),
        .status   (status),
        .err_cnt  (err_cnt),
        .lock_low (lock_low),
        .unlock   (unlock)
    );

    assign pump_up_n = ~(state == PH_REF_LEAD);
    assign pump_dn   = (state == PH_VCO_LEAD);
    assign lock_det  = ~lock_low;
endmodule

// File: rtl/pfd_lock_chk.sv
module pfd_lock_chk (
    input logic clk,
    input logic rst,
    input logic pump_up_n,
    input logic pump_dn,
    input logic lock_det,
    input logic unlock
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (pump_up_n && !pump_dn && lock_det && unlock));

    // R6
    pump_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!pump_up_n && pump_dn));

    // R10
    ld_needs_pump_chk: assert property (@(posedge clk) disable iff (rst)
        !lock_det |-> (!pump_up_n || pump_dn));

    // R8
    unlock_on_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !lock_det |=> unlock);

    // R9
    unlock_fall_clean_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(unlock) |-> $past(lock_det));
endmodule

bind pfd_lock_top pfd_lock_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pump_up_n (pump_up_n),
    .pump_dn   (pump_dn),
    .lock_det  (lock_det),
    .unlock    (unlock)
);

// File: tb/pfd_lock_top_tb.sv
`timescale 1ns/1ps
module pfd_lock_top_tb;
    localparam int WIN    = 4;
    localparam int RELOCK = 3;
    localparam int NV     = 8;
    localparam int LEN    = 40;
    // fields: ref_first, lead, exp_up_cycles, exp_dn_cycles, exp_low_cycles
    localparam int VEC [NV][5] = '{
        '{1, 3, 3, 0, 0},
        '{0, 3, 0, 3, 0},
        '{1, 0, 0, 0, 0},
        '{1, 4, 4, 0, 0},
        '{1, 5, 5, 0, 1},
        '{0, 7, 0, 7, 3},
        '{0, 1, 0, 1, 0},
        '{1, 9, 9, 0, 5}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_pulse = 1'b0;
    logic vco_pulse = 1'b0;
    logic pump_up_n, pump_dn, lock_det, unlock;

    int errors = 0;
    int checks = 0;
    bit meas_en = 1'b0;
    bit finished = 1'b0;
    int n_up, n_dn, n_low, n_both;

    always #2.5 clk = ~clk;

    pfd_lock_top #(.SYNC_STAGES(2), .LOCK_WIN(WIN), .RELOCK_CNT(RELOCK)) u_dut (
        .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .vco_pulse(vco_pulse),
        .pump_up_n(pump_up_n), .pump_dn(pump_dn), .lock_det(lock_det), .unlock(unlock)
    );

    always @(negedge clk) begin
        if (meas_en) begin
            n_up   += (pump_up_n == 1'b0) ? 1 : 0;
            n_dn   += (pump_dn == 1'b1) ? 1 : 0;
            n_low  += (lock_det == 1'b0) ? 1 : 0;
            n_both += (!pump_up_n && pump_dn) ? 1 : 0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit in_pulse(input int t, input int s);
        return (s >= 0) && (t >= s) && (t < s + 2);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ref_pulse = 1'b0; vco_pulse = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_wave(input int r0, input int r1, input int v0);
        @(negedge clk);
        n_up = 0; n_dn = 0; n_low = 0; n_both = 0;
        meas_en = 1'b1;
        for (int t = 0; t < LEN; t++) begin
            ref_pulse = in_pulse(t, r0) | in_pulse(t, r1);
            vco_pulse = in_pulse(t, v0);
            @(negedge clk);
        end
        meas_en = 1'b0;
    endtask

    task automatic cmp(input bit ref_first, input int d);
        if (ref_first) run_wave(0, -100, d);
        else           run_wave(d, -100, 0);
    endtask

    initial begin
        do_reset();
        // R1: reset values, sampled while reset is still held and just after
        rst = 1'b1;
        @(negedge clk);
        check("R1 pump_up_n", pump_up_n, 1);
        check("R1 pump_dn", pump_dn, 0);
        check("R1 lock_det", lock_det, 1);
        check("R1 unlock", unlock, 1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 unlock after release", unlock, 1);

        for (int i = 0; i < NV; i++) begin
            cmp(VEC[i][0] != 0, VEC[i][1]);
            check(VEC[i][0] != 0 ? "R2 up width" : "R3 up width", n_up, VEC[i][2]);
            check(VEC[i][0] != 0 ? "R2 dn width" : "R3 dn width", n_dn, VEC[i][3]);
            check(VEC[i][1] == 0 ? "R4 ld low cycles" : "R7 ld low cycles", n_low, VEC[i][4]);
            check("R6 both pumps", n_both, 0);
            if (VEC[i][4] > 0) check("R8 unlock after pulse", unlock, 1);
        end

        // R5: repeated reference edge before the oscillator edge
        run_wave(0, 4, 6);
        check("R5 up width", n_up, 6);
        check("R5 dn width", n_dn, 0);
        check("R7 ld low on R5 run", n_low, 2);

        // R9: relock counting
        do_reset();
        cmp(1'b1, 2);
        cmp(1'b0, 2);
        check("R9 unlock after 2 clean", unlock, 1);
        cmp(1'b1, 0);
        check("R9 unlock after 3 clean", unlock, 0);
        cmp(1'b1, 6);
        check("R8 unlock after bad", unlock, 1);
        cmp(1'b1, 3);
        cmp(1'b0, 3);
        cmp(1'b0, 5);
        check("R9 unlock after restart", unlock, 1);
        cmp(1'b1, 4);
        cmp(1'b0, 1);
        check("R9 unlock after 2 of new run", unlock, 1);
        cmp(1'b1, 2);
        check("R9 unlock cleared", unlock, 0);
        check("R7 lock_det idle high", lock_det, 1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule